// File: doc/BRIEF.md
# Interleaved ROM Block Deinterleaver

This block converts a cartridge image held in a split-half block layout into a plain linear byte image as the image streams past. Bytes arrive one per handshake, with valid, ready and an end-of-stream marker on the final byte. The block consumes a fixed-length header and forwards none of it. From the header it keeps two facts: whether the image is one part of a multi-part set, and whether the two signature bytes hold their usual values. The header's own block-count byte is never used. The number of converted blocks comes only from the data that actually arrives.

After the header, the data comes in blocks of `2**BLK_LOG2` bytes. The real format uses `BLK_LOG2 = 14`. The default is smaller so that the buffer stays modest. Each block is captured whole in an internal buffer. Bytes from the first half of the block go to odd output positions and bytes from the second half go to even ones. The block is then streamed out in ascending address order under valid/ready backpressure. A block-done pulse and a converted-block count follow each drained block. A short final block is dropped and flagged. Once the end-of-stream byte is handled, the block waits for the header of a new image.

Top module: `rom_deinterleave`

## Requirements
- R1: The first `HDR_BYTES` accepted bytes of each image are consumed as header and never appear on the output.
- R2: `multi_part` is 1 when header byte 2 is nonzero and 0 when it is zero, and holds until the next image starts.
- R3: `sig_warn` is 1 when header byte 8 differs from `SIG_A` (0xAA) or header byte 9 differs from `SIG_B` (0xBB). Conversion of the blocks that follow goes ahead regardless.
- R4: Within a block, input byte `i` for `i < BLK/2` is output at block position `2*i+1`, and input byte `BLK/2+i` is output at block position `2*i`.
- R5: No output is produced until a whole block has been accepted. Input is refused (`in_ready` low) while a block is being emitted. Each block leaves in increasing output position, starting in the cycle after its final byte is accepted.
- R6: `trunc_err` is set when the end-of-stream marker arrives inside a block or before the header is complete. The bytes of such a partial block are never emitted.
- R7: `blk_done` pulses for exactly one cycle after the final byte of each block is transferred, and `blk_count` advances by one at that point. The value of header byte 0 has no effect on the count.
- R8: The first header byte of a new image clears `multi_part`, `sig_warn`, `trunc_err` and `blk_count`. An image consisting of a complete header and nothing else yields no output and no error.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R10: After reset, `in_ready` is 1, `out_valid` is 0, all flags are 0 and `blk_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte in linear order |
| out_ready | input | 1 | Consumer takes the output byte |
| multi_part | output | 1 | Header byte 2 was nonzero |
| sig_warn | output | 1 | Signature bytes did not match |
| trunc_err | output | 1 | Stream ended mid-block or mid-header |
| blk_done | output | 1 | One-cycle pulse per drained block |
| blk_count | output | CNT_W | Blocks converted in the current image |

## Verification
The bench targets the half-to-parity mapping. A design that swapped the halves, or mapped them onto the wrong parity, would put every byte one position off, and the byte-by-byte comparison against the reference queue would show it. It runs images whose stream ends exactly at a block boundary, one byte into a block, in the middle of the header and right at the end of the header. A design that emitted the stub block, failed to flag it, or flagged a clean header-only image would show surplus output or a wrong `trunc_err`. Bad signature bytes, a misleading header count byte and output backpressure expose a design that stops converting on a warning, counts from the header, or lets data slip during a stall. A later image checks that the flags from an earlier one are cleared.

// File: rtl/rom_deinterleave.sv
module rom_deinterleave #(
  parameter int HDR_BYTES = 512,
  parameter int BLK_LOG2  = 11,
  parameter int CNT_W     = 16,
  parameter logic [7:0] SIG_A = 8'hAA,
  parameter logic [7:0] SIG_B = 8'hBB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             multi_part,
  output logic             sig_warn,
  output logic             trunc_err,
  output logic             blk_done,
  output logic [CNT_W-1:0] blk_count
);
  localparam int BLK = 1 << BLK_LOG2;
  localparam int HW  = $clog2(HDR_BYTES);
  localparam int IW  = (HW > BLK_LOG2) ? HW : BLK_LOG2;

  typedef enum logic [1:0] {S_HDR, S_FILL, S_DRAIN} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic          fin;
  logic [7:0]    mem [BLK];

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;
  wire hdr_end  = idx == IW'(HDR_BYTES - 1);
  wire blk_end  = idx == IW'(BLK - 1);
  wire [BLK_LOG2-1:0] pos   = idx[BLK_LOG2-1:0];
  wire [BLK_LOG2-1:0] waddr = {pos[BLK_LOG2-2:0], ~pos[BLK_LOG2-1]};

  assign in_ready  = (st == S_HDR) || (st == S_FILL);
  assign out_valid = (st == S_DRAIN);
  assign out_data  = mem[pos];

  always_ff @(posedge clk)
    if (st == S_FILL && in_fire) mem[waddr] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HDR;
      idx        <= '0;
      fin        <= 1'b0;
      multi_part <= 1'b0;
      sig_warn   <= 1'b0;
      trunc_err  <= 1'b0;
      blk_done   <= 1'b0;
      blk_count  <= '0;
    end else begin
      blk_done <= 1'b0;
      case (st)
        S_HDR: if (in_fire) begin
          if (idx == IW'(0)) begin
            multi_part <= 1'b0;
            sig_warn   <= 1'b0;
            trunc_err  <= 1'b0;
            blk_count  <= '0;
          end
          if (idx == IW'(2)) multi_part <= |in_data;
          if (idx == IW'(8)) sig_warn <= (in_data != SIG_A);
          if (idx == IW'(9)) sig_warn <= sig_warn | (in_data != SIG_B);
          if (in_last) begin
            idx <= '0;
            if (!hdr_end) trunc_err <= 1'b1;
          end else if (hdr_end) begin
            idx <= '0;
            st  <= S_FILL;
          end else idx <= idx + 1'b1;
        end
        S_FILL: if (in_fire) begin
          if (blk_end) begin
            idx <= '0;
            fin <= in_last;
            st  <= S_DRAIN;
          end else if (in_last) begin
            idx       <= '0;
            trunc_err <= 1'b1;
            st        <= S_HDR;
          end else idx <= idx + 1'b1;
        end
        S_DRAIN: if (out_fire) begin
          if (blk_end) begin
            idx       <= '0;
            blk_done  <= 1'b1;
            blk_count <= blk_count + 1'b1;
            st        <= fin ? S_HDR : S_FILL;
          end else idx <= idx + 1'b1;
        end
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/deint_checks.sv
module deint_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             blk_done,
  input logic [CNT_W-1:0] blk_count
);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_drain_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (blk_count == CNT_W'($past(blk_count) + 1'b1)));
endmodule

bind rom_deinterleave deint_checks #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .blk_done(blk_done), .blk_count(blk_count)
);

// File: tb/sim_rom_deinterleave.sv
module sim_rom_deinterleave;
  localparam int T   = 10;
  localparam int HDR = 16;
  localparam int BL  = 5;
  localparam int BLK = 1 << BL;
  localparam int CW  = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, multi_part, sig_warn, trunc_err, blk_done;
  logic [7:0] out_data;
  logic [CW-1:0] blk_count;

  rom_deinterleave #(.HDR_BYTES(HDR), .BLK_LOG2(BL), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .multi_part(multi_part),
    .sig_warn(sig_warn), .trunc_err(trunc_err), .blk_done(blk_done),
    .blk_count(blk_count));

  always #(T/2) clk = ~clk;

  int checks = 0, errors = 0, pulses = 0, cyc = 0;
  bit stall_mode = 0, prev_stall = 0;
  logic [7:0] prev_data;
  logic [7:0] expq[$];

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    if (rst_n) begin
      if (blk_done) pulses++;
      if (prev_stall) chk("R9 held data", out_data, prev_data);
      if (in_ready && out_valid) chk("R5 overlap", 1, 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk("R1/R6 unexpected output", 1, 0);
        else chk("R4 output byte", out_data, expq.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic put(logic [7:0] b, logic l);
    in_valid = 1; in_data = b; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic send_image(logic [7:0] b0, logic [7:0] b2, logic [7:0] b8,
                            logic [7:0] b9, int hlen, int nblk, int tail, int seed);
    logic [7:0] hb, blk[BLK];
    int total = hlen + nblk * BLK + tail, sent = 0;
    pulses = 0;
    for (int i = 0; i < hlen; i++) begin
      hb = (i == 0) ? b0 : (i == 2) ? b2 : (i == 8) ? b8 : (i == 9) ? b9 : 8'(i * 7 + 3);
      sent++;
      put(hb, sent == total);
    end
    for (int k = 0; k < nblk; k++) begin
      for (int i = 0; i < BLK; i++) blk[i] = 8'(i * 13 + k * 29 + seed);
      for (int p = 0; p < BLK; p++)
        expq.push_back((p % 2 == 1) ? blk[(p - 1) / 2] : blk[BLK / 2 + p / 2]);
      for (int i = 0; i < BLK; i++) begin
        sent++;
        put(blk[i], sent == total);
      end
    end
    for (int i = 0; i < tail; i++) begin
      sent++;
      put(8'(i + 100), sent == total);
    end
    for (int g = 0; g < 5000 && (expq.size() != 0 || out_valid); g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 in_ready", in_ready, 1);
    chk("R10 out_valid", out_valid, 0);
    chk("R10 flags", {multi_part, sig_warn, trunc_err}, 0);
    chk("R10 count", blk_count, 0);

    // two clean blocks with output backpressure
    stall_mode = 1;
    send_image(8'd2, 8'd0, 8'hAA, 8'hBB, HDR, 2, 0, 5);
    stall_mode = 0;
    chk("R1/R4 queue drained", expq.size(), 0);
    chk("R2 multi_part clear", multi_part, 0);
    chk("R3 sig ok", sig_warn, 0);
    chk("R6 no trunc", trunc_err, 0);
    chk("R7 count", blk_count, 2);
    chk("R7 pulses", pulses, 2);

    // bad signature, set member, stub tail
    send_image(8'd1, 8'd5, 8'hAA, 8'h12, HDR, 1, 7, 77);
    chk("R3 sig bad still converts", expq.size(), 0);
    chk("R3 sig_warn", sig_warn, 1);
    chk("R2 multi_part set", multi_part, 1);
    chk("R6 stub flagged", trunc_err, 1);
    chk("R6 stub not counted", blk_count, 1);

    // header only: flags cleared by new image
    send_image(8'd9, 8'd0, 8'hAA, 8'hBB, HDR, 0, 0, 0);
    chk("R8 warn cleared", sig_warn, 0);
    chk("R8 multi_part cleared", multi_part, 0);
    chk("R8 no error", trunc_err, 0);
    chk("R8 count cleared", blk_count, 0);

    // truncated header
    send_image(8'd4, 8'd1, 8'hAA, 8'hBB, 5, 0, 0, 0);
    chk("R6 short header", trunc_err, 1);
    chk("R6 short header count", blk_count, 0);

    // misleading count byte, bad first signature byte, one data byte tail
    send_image(8'd99, 8'd0, 8'h00, 8'hBB, HDR, 1, 1, 200);
    chk("R7 count ignores header", blk_count, 1);
    chk("R7 one pulse", pulses, 1);
    chk("R3 first sig byte", sig_warn, 1);
    chk("R6 one-byte stub", trunc_err, 1);
    chk("R6 nothing extra", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule